// File: doc/BRIEF.md
# Dual X/Y Word Address Generator

This block produces two data-memory word addresses in the same cycle, one for an X memory and one for a Y memory, so that a pair of 16-bit transfers can proceed side by side. Four pointer registers are split into fixed pairs: the X side picks one of pointers 0 and 1, and the Y side picks one of pointers 2 and 3. Each side has its own stride (index) register. Every access is a post-update: the pointer's old value goes out as the address, and the pointer is then kept, advanced by one word (2 bytes), or advanced by the side's stride.

An optional wrap window, set by a low and a high bound, can be attached to either side but never to both at once. When the window is on and a post-update would move past the high bound, the pointer is reloaded with the low bound. All pointers, strides, bounds and the wrap configuration are written through a single load port. The two sides use separate memories, so they never stall each other. Both results come from registers and appear one cycle after the request.

Top module: `xy_addr_gen`

## Requirements
- R1: After reset, every pointer, both strides, both bounds and the wrap configuration are zero, and `x_valid` and `y_valid` are low.
- R2: A request with `x_en` high in cycle n sets `x_valid` in cycle n+1 with `x_addr` equal to the value that the chosen pointer (`x_sel`=0: pointer 0, 1: pointer 1) held in cycle n, with bit 0 cleared. The Y side behaves the same way with pointers 2 and 3.
- R3: Step codes 0 and 3 leave the chosen pointer unchanged.
- R4: Step code 1 adds 2 to the chosen pointer, modulo 2^AW.
- R5: Step code 2 adds the side's stride (code 4 for X, code 5 for Y) to the chosen pointer, modulo 2^AW.
- R6: With wrap on for a side (config bit 0 set; bit 1 = 0 picks X, 1 picks Y), a step-1 or step-2 result above the high bound (code 7) is replaced by the low bound (code 6). The other side is not affected.
- R7: Load codes 0..3 write pointers 0..3, 4 and 5 the X and Y strides, 6 the low bound, 7 the high bound, 8 the wrap configuration (bits 1:0). A load takes effect at the clock edge and is seen by requests from the next cycle on.
- R8: If a load and a step-1 or step-2 update hit the same pointer in one cycle, the update is kept and the load is lost. With step code 0 or 3 the load lands.
- R9: While a side's enable is low, its pointers keep their value, its valid is low in the next cycle and its select and step code are ignored.
- R10: X and Y requests in the same cycle are both served in the next cycle, each from its own pointer pair and stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Load strobe |
| ld_code | input | 4 | Register to load (see R7) |
| ld_data | input | AW | Load value |
| x_en | input | 1 | X side request |
| x_sel | input | 1 | X pointer choice (0: pointer 0, 1: pointer 1) |
| x_step | input | 2 | X post-update code |
| y_en | input | 1 | Y side request |
| y_sel | input | 1 | Y pointer choice (0: pointer 2, 1: pointer 3) |
| y_step | input | 2 | Y post-update code |
| x_addr | output | AW | X word address |
| x_valid | output | 1 | X address strobe |
| y_addr | output | AW | Y word address |
| y_valid | output | 1 | Y address strobe |

## Verification
Each address and strobe is due exactly one cycle after its request: the bench drives the inputs on the falling edge, lets one rising edge pass and samples just after it. A pointer update or a load shows only in the address of the next request to that pointer, which is two edges after the cycle that changed it. The bench's model follows this by taking the address from its old pointer value before it applies loads and then updates. Stride, bound and wrap-configuration loads made in cycle n therefore affect only requests from cycle n+1 on.

// File: rtl/xyag_pkg.sv
package xyag_pkg;

  // post-update step codes
  typedef enum logic [1:0] {
    STEP_KEEP  = 2'd0,
    STEP_WORD  = 2'd1,
    STEP_INDEX = 2'd2,
    STEP_KEEP2 = 2'd3
  } step_e;

  localparam int LDW = 4;

  // load-port register codes
  localparam logic [LDW-1:0] LD_PTR0   = 4'd0;
  localparam logic [LDW-1:0] LD_PTR1   = 4'd1;
  localparam logic [LDW-1:0] LD_PTR2   = 4'd2;
  localparam logic [LDW-1:0] LD_PTR3   = 4'd3;
  localparam logic [LDW-1:0] LD_STRX   = 4'd4;
  localparam logic [LDW-1:0] LD_STRY   = 4'd5;
  localparam logic [LDW-1:0] LD_WLO    = 4'd6;
  localparam logic [LDW-1:0] LD_WHI    = 4'd7;
  localparam logic [LDW-1:0] LD_WCFG   = 4'd8;

endpackage

// File: rtl/xyag_regs.sv
module xyag_regs
  import xyag_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [LDW-1:0]            ld_code,
  input  logic [AW-1:0]             ld_data,
  input  logic [1:0]                upd_we,
  input  logic [1:0]                upd_sel,
  input  logic [1:0][AW-1:0]        upd_val,
  output logic [NPTR-1:0][AW-1:0]   ptr_q,
  output logic [AW-1:0]             stride_x,
  output logic [AW-1:0]             stride_y,
  output logic [AW-1:0]             wrap_lo,
  output logic [AW-1:0]             wrap_hi,
  output logic                      wrap_on_x,
  output logic                      wrap_on_y
);

  logic [1:0] wcfg_q;       // bit0 enable, bit1 side (0 X, 1 Y)
  logic [NPTR-1:0] upd_hit;
  logic [NPTR-1:0] ld_hit;
  logic [NPTR-1:0] collide;

  genvar gi;
  generate
    for (gi = 0; gi < NPTR; gi++) begin : g_ptr
      localparam int LN = gi / 2;
      localparam int WI = gi % 2;

      assign upd_hit[gi] = upd_we[LN] && (upd_sel[LN] == 1'(WI));
      assign ld_hit[gi]  = ld_en && (ld_code == LDW'(gi));
      assign collide[gi] = upd_hit[gi] && ld_hit[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ptr_q[gi] <= '0;
        else if (upd_hit[gi]) ptr_q[gi] <= upd_val[LN];
        else if (ld_hit[gi])  ptr_q[gi] <= ld_data;
      end

      assert_update_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        collide[gi] |=> ptr_q[gi] == $past(upd_val[LN]));

      assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_hit[gi] && !ld_hit[gi]) |=> $stable(ptr_q[gi]));

      assert_load_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_hit[gi] && !upd_hit[gi]) |=> ptr_q[gi] == $past(ld_data));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_x <= '0;
      stride_y <= '0;
      wrap_lo  <= '0;
      wrap_hi  <= '0;
      wcfg_q   <= '0;
    end else if (ld_en) begin
      case (ld_code)
        LD_STRX: stride_x <= ld_data;
        LD_STRY: stride_y <= ld_data;
        LD_WLO:  wrap_lo  <= ld_data;
        LD_WHI:  wrap_hi  <= ld_data;
        LD_WCFG: wcfg_q   <= ld_data[1:0];
        default: ;
      endcase
    end
  end

  assign wrap_on_x = wcfg_q[0] && !wcfg_q[1];
  assign wrap_on_y = wcfg_q[0] &&  wcfg_q[1];

endmodule

// File: rtl/xyag_lane.sv
module xyag_lane
  import xyag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic [1:0]    step,
  input  logic [AW-1:0] ptr_lo,
  input  logic [AW-1:0] ptr_hi,
  input  logic [AW-1:0] stride,
  input  logic          wrap_on,
  input  logic [AW-1:0] wrap_lo,
  input  logic [AW-1:0] wrap_hi,
  output logic [AW-1:0] addr_q,
  output logic          valid_q,
  output logic          upd_we,
  output logic          upd_sel,
  output logic [AW-1:0] upd_val
);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] cur,
                                            input logic [AW-1:0] inc,
                                            input logic [1:0]    code);
    case (step_e'(code))
      STEP_WORD:  return cur + AW'(2);
      STEP_INDEX: return cur + inc;
      default:    return cur;
    endcase
  endfunction

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] nxt,
                                         input logic          on,
                                         input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    if (on && (nxt > hi)) return lo;
    return nxt;
  endfunction

  logic [AW-1:0] cur;
  logic [AW-1:0] stepped;
  logic          moves;
  logic          wrapped;

  assign cur     = sel ? ptr_hi : ptr_lo;
  assign moves   = (step == STEP_WORD) || (step == STEP_INDEX);
  assign stepped = advance(cur, stride, step);
  assign upd_val = fold(stepped, wrap_on, wrap_lo, wrap_hi);
  assign wrapped = upd_val != stepped;
  assign upd_we  = en && moves;
  assign upd_sel = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
      if (en) addr_q <= {cur[AW-1:1], 1'b0};
    end
  end

  assert_wrap_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_we && wrapped) |-> (wrap_on && upd_val == wrap_lo));

  assert_issue_old_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (valid_q && addr_q[AW-1:1] == $past(cur[AW-1:1]) && !addr_q[0]));

endmodule

// File: rtl/xy_addr_gen.sv
module xy_addr_gen
  import xyag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [3:0]    ld_code,
  input  logic [AW-1:0] ld_data,
  input  logic          x_en,
  input  logic          x_sel,
  input  logic [1:0]    x_step,
  input  logic          y_en,
  input  logic          y_sel,
  input  logic [1:0]    y_step,
  output logic [AW-1:0] x_addr,
  output logic          x_valid,
  output logic [AW-1:0] y_addr,
  output logic          y_valid
);

  localparam int NPTR = 4;
  localparam int NSIDE = 2;

  logic [NPTR-1:0][AW-1:0]  ptr_q;
  logic [AW-1:0]            stride_x, stride_y, wrap_lo, wrap_hi;
  logic                     wrap_on_x, wrap_on_y;
  logic [NSIDE-1:0]         upd_we, upd_sel;
  logic [NSIDE-1:0][AW-1:0] upd_val;
  logic [NSIDE-1:0]         side_en, side_sel, side_wrap, side_valid;
  logic [NSIDE-1:0][1:0]    side_step;
  logic [NSIDE-1:0][AW-1:0] side_stride, side_addr;

  assign side_en     = {y_en, x_en};
  assign side_sel    = {y_sel, x_sel};
  assign side_step   = {y_step, x_step};
  assign side_stride = {stride_y, stride_x};
  assign side_wrap   = {wrap_on_y, wrap_on_x};

  xyag_regs #(.AW(AW), .NPTR(NPTR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_code(ld_code), .ld_data(ld_data),
    .upd_we(upd_we), .upd_sel(upd_sel), .upd_val(upd_val),
    .ptr_q(ptr_q),
    .stride_x(stride_x), .stride_y(stride_y),
    .wrap_lo(wrap_lo), .wrap_hi(wrap_hi),
    .wrap_on_x(wrap_on_x), .wrap_on_y(wrap_on_y)
  );

  genvar gs;
  generate
    for (gs = 0; gs < NSIDE; gs++) begin : g_side
      xyag_lane #(.AW(AW)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .en(side_en[gs]), .sel(side_sel[gs]), .step(side_step[gs]),
        .ptr_lo(ptr_q[2*gs]), .ptr_hi(ptr_q[2*gs+1]),
        .stride(side_stride[gs]),
        .wrap_on(side_wrap[gs]), .wrap_lo(wrap_lo), .wrap_hi(wrap_hi),
        .addr_q(side_addr[gs]), .valid_q(side_valid[gs]),
        .upd_we(upd_we[gs]), .upd_sel(upd_sel[gs]), .upd_val(upd_val[gs])
      );
    end
  endgenerate

  assign x_addr  = side_addr[0];
  assign y_addr  = side_addr[1];
  assign x_valid = side_valid[0];
  assign y_valid = side_valid[1];

  assert_valid_follows_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !x_en |=> !x_valid);

  assert_valid_follows_enable_y_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !y_en |=> !y_valid);

  assert_both_served_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (x_en && y_en) |=> (x_valid && y_valid));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!x_valid && !y_valid));

endmodule

// File: tb/test_xy_addr_gen.sv
module test_xy_addr_gen;

  localparam int AW = 16;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic [3:0]    ld_code = '0;
  logic [AW-1:0] ld_data = '0;
  logic          x_en = 1'b0, x_sel = 1'b0, y_en = 1'b0, y_sel = 1'b0;
  logic [1:0]    x_step = '0, y_step = '0;
  logic [AW-1:0] x_addr, y_addr;
  logic          x_valid, y_valid;

  xy_addr_gen #(.AW(AW)) i_xy_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_code(ld_code), .ld_data(ld_data),
    .x_en(x_en), .x_sel(x_sel), .x_step(x_step),
    .y_en(y_en), .y_sel(y_sel), .y_step(y_step),
    .x_addr(x_addr), .x_valid(x_valid),
    .y_addr(y_addr), .y_valid(y_valid)
  );

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;

  // bench model
  int mp[4];
  int ms[2];
  int mlo, mhi, mcfg;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int side_wrap(input int side);
    return ((mcfg & 1) != 0) && (((mcfg >> 1) & 1) == side);
  endfunction

  // one request cycle; returns nothing, checks both sides after the edge
  task automatic cyc(input bit xe, input bit xs, input int xm,
                     input bit ye, input bit ys, input int ym,
                     input bit le, input int lc, input int ldv,
                     input string force_tag);
    int  en[2], sl[2], md[2];
    int  ea[2], nv[2];
    bit  mv[2];
    string tg[2];
    en[0] = xe; sl[0] = xs; md[0] = xm;
    en[1] = ye; sl[1] = ys; md[1] = ym;
    @(negedge clk);
    x_en = xe; x_sel = xs; x_step = 2'(xm);
    y_en = ye; y_sel = ys; y_step = 2'(ym);
    ld_en = le; ld_code = 4'(lc); ld_data = AW'(ldv);
    for (int s = 0; s < 2; s++) begin
      int slot = 2 * s + sl[s];
      int raw;
      ea[s] = mp[slot] & (MASK - 1);
      mv[s] = en[s] != 0 && (md[s] == 1 || md[s] == 2);
      raw = (md[s] == 1) ? (mp[slot] + 2) & MASK :
            (md[s] == 2) ? (mp[slot] + ms[s]) & MASK : mp[slot];
      nv[s] = raw;
      if (en[s] == 0)                           tg[s] = "R9";
      else if (force_tag != "")                 tg[s] = force_tag;
      else if (mv[s] && side_wrap(s) && raw > mhi) tg[s] = "R6";
      else if (md[s] == 1)                      tg[s] = "R4";
      else if (md[s] == 2)                      tg[s] = "R5";
      else                                      tg[s] = "R3";
      if (mv[s] && side_wrap(s) && raw > mhi) nv[s] = mlo;
    end
    // loads, then updates override
    if (le) begin
      case (lc)
        0, 1, 2, 3: mp[lc] = ldv & MASK;
        4: ms[0] = ldv & MASK;
        5: ms[1] = ldv & MASK;
        6: mlo = ldv & MASK;
        7: mhi = ldv & MASK;
        8: mcfg = ldv & 3;
        default: ;
      endcase
    end
    for (int s = 0; s < 2; s++)
      if (mv[s]) mp[2 * s + sl[s]] = nv[s];
    @(posedge clk);
    #1;
    chk((xe && ye) ? "R10" : (xe ? "R2" : "R9"), int'(x_valid), int'(xe));
    chk((xe && ye) ? "R10" : (ye ? "R2" : "R9"), int'(y_valid), int'(ye));
    if (xe) chk(tg[0], int'(x_addr), ea[0]);
    if (ye) chk(tg[1], int'(y_addr), ea[1]);
  endtask

  task automatic load(input int code, input int v);
    cyc(0, 0, 0, 0, 0, 0, 1, code, v, "");
  endtask

  task automatic read_all(input string tag);
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 0, tag);
    cyc(1, 1, 3, 1, 1, 3, 0, 0, 0, tag);
  endtask

  task automatic sweep();
    for (int a = 0; a < 256; a++)
      cyc(a[0], a[1], a[3:2], a[4], a[5], a[7:6], 0, 0, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mp[i] = 0;
    ms[0] = 0; ms[1] = 0; mlo = 0; mhi = 0; mcfg = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(x_valid), 0);
    chk("R1", int'(y_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: all pointers read back as zero
    read_all("R1");
    // R7: load every register, then read pointers back
    load(0, 'h0100); load(1, 'h0201); load(2, 'h8000); load(3, 'hFFFE);
    load(4, 'h0010); load(5, 'hFFFC);
    read_all("R7");
    // plain sweep, wrap off (R3 R4 R5 R9 R10, R2 odd pointer, R4 wrap past 2^AW)
    sweep();
    // wrap window on X side
    load(6, 'h0100); load(7, 'h0140); load(8, 1);
    load(0, 'h0100); load(1, 'h013E);
    sweep();
    // wrap window on Y side, X window released
    load(6, 'h7FF0); load(7, 'h8008); load(8, 3);
    load(2, 'h8000); load(3, 'h8006); load(5, 'h0006);
    sweep();
    // R6: single explicit wrap on Y while X unaffected
    load(3, 'h8008);
    cyc(1, 1, 1, 1, 1, 1, 0, 0, 0, "R6");
    cyc(1, 1, 0, 1, 1, 0, 0, 0, 0, "R6");
    // R8: load and step on same pointer, step wins
    load(8, 0);
    load(0, 'h1000);
    cyc(1, 0, 1, 0, 0, 0, 1, 0, 'h5554, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R8: load with hold step lands
    cyc(1, 0, 0, 0, 0, 0, 1, 0, 'h2222, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R9: disabled side ignores step codes
    cyc(0, 0, 1, 0, 1, 2, 0, 0, 0, "R9");
    read_all("R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule